// File: doc/BRIEF.md
# Load-Use Hazard Stall Detector

This block finds a read-after-load dependency in a five-stage in-order pipeline before the dependent instruction leaves fetch. Each cycle it compares the source register fields of the instruction just fetched with the destination of the instruction in decode. It does this only for the source fields that the fetched instruction actually reads, and only when the decode-stage instruction is a load. On a match it requests one stall cycle. During that cycle the program counter and the fetch/decode register hold, and a no-operation with all control cleared goes into the decode/execute register.

The decision is made while the consumer is still in fetch. For that reason a stall can be charged to a wrong-path instruction that a taken branch in execute is about to squash. The branch flush input does not cancel a stall decided in the same cycle. It does force the bubble into decode/execute, whatever the stall logic decides. One state bit marks that a stall was just taken. Because the held load is still visible in decode during the next cycle, this bit stops the same dependency from causing a second stall, so each load-use pair costs exactly one cycle.

Top module: `hzd_load_use`

## Requirements
- R1: When `id_load_i` is 1, `id_rd_i` is nonzero, `if_use_rs1_i` is 1 and `if_rs1_i` equals `id_rd_i`, then `pc_hold_o`, `ifid_hold_o` and `idex_bubble_o` are all 1 in that same cycle. The only exception is the cycle after a stall (see R5).
- R2: The same stall occurs through the second source field. This happens when `if_use_rs2_i` is 1 and `if_rs2_i` equals `id_rd_i`, as for the data register of a store or the second operand of a compare-and-branch.
- R3: A load whose destination is register 0 (`id_rd_i` = 0) never causes a stall, whatever the source fields hold.
- R4: A source field that matches but has its use flag at 0 causes no stall. When `id_load_i` is 0, no stall occurs at all.
- R5: A stall lasts exactly one cycle. If the hazard pattern is still present in the cycle right after a stall, all three outputs are 0 in that cycle. The next cycle is free to stall again.
- R6: `pc_hold_o` and `ifid_hold_o` are always equal. Whenever they are 1, `idex_bubble_o` is 1 too.
- R7: `flush_i` = 1 forces `idex_bubble_o` to 1. It does not suppress a stall decided in the same cycle: `pc_hold_o` and `ifid_hold_o` still follow R1 to R5.
- R8: While `rst_ni` is 0 and after it is released, the block holds no pending stall. With no hazard at the inputs, all outputs are 0, and the first hazard after reset stalls at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_rs1_i | input | REG_W | First source register field of the fetched instruction |
| if_rs2_i | input | REG_W | Second source register field of the fetched instruction |
| if_use_rs1_i | input | 1 | The fetched instruction reads its first source |
| if_use_rs2_i | input | 1 | The fetched instruction reads its second source |
| id_load_i | input | 1 | The decode-stage instruction is a load |
| id_rd_i | input | REG_W | Destination register of the decode-stage instruction |
| flush_i | input | 1 | Taken-branch flush from execute |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| idex_bubble_o | output | 1 | Load a cleared no-operation into decode/execute |

## Verification
A stall and a branch flush can fall in the same cycle. This is the wrong-path case: a taken branch in execute, a load in decode and a dependent instruction in fetch. The bench sets up that combination on purpose, both on a fresh hazard and on the cycle right after a stall. It checks that the hold outputs keep to the stall rule while the bubble is forced on. A behavioural model runs alongside and recomputes, on every clock, whether a stall was just taken. This is compared against all three outputs during directed sequences and a long pseudo-random sequence.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned REG_W    = $clog2(NUM_REGS);
  localparam int unsigned NUM_SRC  = 2;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HELD = 1'b1
  } hzd_state_e;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int unsigned REG_W   = hzd_pkg::REG_W,
  parameter int unsigned NUM_SRC = hzd_pkg::NUM_SRC
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] src_i,
  input  logic [NUM_SRC-1:0]            use_i,
  input  logic                          load_i,
  input  logic [REG_W-1:0]              rd_i,
  output logic                          hit_o
);
  logic [NUM_SRC-1:0] match;
  logic               rd_live;

  // register 0 is hardwired, never a real producer
  assign rd_live = load_i && (rd_i != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign match[g] = use_i[g] && (src_i[g] == rd_i);
  end

  assign hit_o = rd_live && (|match);

  // R4: no read means no hit
  always_comb begin
    a_r4_unused_src: assert (!(hit_o && (use_i == '0)));
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic flush_i,
  output logic pc_hold_o,
  output logic ifid_hold_o,
  output logic idex_bubble_o
);
  import hzd_pkg::*;

  hzd_state_e st_q;
  logic       stall;

  // held load still visible in ID next cycle; block a repeat stall
  assign stall = hit_i && (st_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= stall ? ST_HELD : ST_RUN;
  end

  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  // flush owns ID/EX; it never cancels the hold
  assign idex_bubble_o = stall || flush_i;

  a_r5_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |=> !pc_hold_o);

  a_r5_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_hold_o && hit_i) |=> ##1 (hit_i |-> pc_hold_o));

  a_r6_hold_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_hold_o == ifid_hold_o) && (!pc_hold_o || idex_bubble_o));

  a_r7_flush_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> idex_bubble_o);
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int unsigned REG_W = hzd_pkg::REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] if_rs1_i,
  input  logic [REG_W-1:0] if_rs2_i,
  input  logic             if_use_rs1_i,
  input  logic             if_use_rs2_i,
  input  logic             id_load_i,
  input  logic [REG_W-1:0] id_rd_i,
  input  logic             flush_i,
  output logic             pc_hold_o,
  output logic             ifid_hold_o,
  output logic             idex_bubble_o
);
  localparam int unsigned NSRC = hzd_pkg::NUM_SRC;

  logic [NSRC-1:0][REG_W-1:0] src;
  logic [NSRC-1:0]            src_use;
  logic                       hit;

  assign src     = {if_rs2_i, if_rs1_i};
  assign src_use = {if_use_rs2_i, if_use_rs1_i};

  hzd_src_match #(
    .REG_W   (REG_W),
    .NUM_SRC (NSRC)
  ) u_match (
    .src_i  (src),
    .use_i  (src_use),
    .load_i (id_load_i),
    .rd_i   (id_rd_i),
    .hit_o  (hit)
  );

  hzd_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hit_i         (hit),
    .flush_i       (flush_i),
    .pc_hold_o     (pc_hold_o),
    .ifid_hold_o   (ifid_hold_o),
    .idex_bubble_o (idex_bubble_o)
  );

  a_r3_x0_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_load_i && (id_rd_i == '0)) |-> !pc_hold_o);

  a_r4_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_load_i |-> !(pc_hold_o || ifid_hold_o));

  a_r1_rs1_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_load_i && (id_rd_i != '0) && if_use_rs1_i && (if_rs1_i == id_rd_i)
     && !$past(pc_hold_o)) |-> pc_hold_o);
endmodule

// File: tb/sim_hzd_load_use.sv
module sim_hzd_load_use;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] rs1 = '0, rs2 = '0, rd = '0;
  logic         u1 = 1'b0, u2 = 1'b0, ld = 1'b0, fl = 1'b0;
  logic         pc_hold, ifid_hold, idex_bubble;

  int n_chk = 0;
  int n_fail = 0;
  bit model_prev = 1'b0;
  bit done = 1'b0;
  int unsigned lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  hzd_load_use #(.REG_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .if_rs1_i(rs1), .if_rs2_i(rs2),
    .if_use_rs1_i(u1), .if_use_rs2_i(u2),
    .id_load_i(ld), .id_rd_i(rd), .flush_i(fl),
    .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .idex_bubble_o(idex_bubble)
  );

  function automatic int unsigned nxt(int unsigned s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic string tag_of(bit hz, bit prev);
    if (fl)                     return "R7";
    if (hz && prev)             return "R5";
    if (ld && rd == 0)          return "R3";
    if (!ld)                    return "R4";
    if (hz && u1 && rs1 == rd)  return "R1";
    if (hz)                     return "R2";
    return "R4";
  endfunction

  // apply at negedge, compare 1 time unit later, advance model at posedge
  task automatic step(input bit l, input logic [W-1:0] d,
                      input bit a1, input logic [W-1:0] s1,
                      input bit a2, input logic [W-1:0] s2,
                      input bit f, input string req);
    bit hz, st;
    logic [2:0] exp_v, got;
    string t;
    @(negedge clk);
    ld = l; rd = d; u1 = a1; rs1 = s1; u2 = a2; rs2 = s2; fl = f;
    #1;
    hz = l && (d != 0) && ((a1 && s1 == d) || (a2 && s2 == d));
    st = rst_n && hz && !model_prev;
    exp_v = {st, st, st || f};
    got = {pc_hold, ifid_hold, idex_bubble};
    t = (req == "") ? tag_of(hz, model_prev) : req;
    n_chk++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s at %0t: got {pc,ifid,bub}=%b expected %b", t, $time, got, exp_v);
    end
    @(posedge clk);
    model_prev = rst_n ? st : 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset state, outputs idle
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    rst_n = 1'b1;
    // R8: first hazard after reset stalls at once; R1 through rs1
    step(1, 5, 1, 5, 0, 0, 0, "R1");
    // R5: same pattern the next cycle gives no stall
    step(1, 5, 1, 5, 0, 0, 0, "R5");
    // R5: re-armed the cycle after
    step(1, 5, 1, 5, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, "R4");
    // R2: store data / branch second operand
    step(1, 7, 1, 3, 1, 7, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R4");
    // R2: both sources match
    step(1, 9, 1, 9, 1, 9, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R4");
    // R3: x0 destination never stalls
    step(1, 0, 1, 0, 1, 0, 0, "R3");
    // R4: matching fields, use flags clear
    step(1, 12, 0, 12, 0, 12, 0, "R4");
    // R4: not a load
    step(0, 12, 1, 12, 1, 12, 0, "R4");
    // R6/R7: flush alone gives bubble only
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    // R7: flush with fresh hazard, stall not suppressed
    step(1, 31, 0, 0, 1, 31, 1, "R7");
    // R7: flush on the cycle after a stall, hazard still present
    step(1, 31, 0, 0, 1, 31, 1, "R7");
    step(1, 31, 0, 0, 1, 31, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, "R6");
    // random sequence, small register space to provoke matches
    for (int i = 0; i < 600; i++) begin
      lfsr = nxt(lfsr);
      step(lfsr[0] | lfsr[9], W'(lfsr[3:1]), lfsr[4], W'(lfsr[7:5]),
           lfsr[8], W'(lfsr[12:10]), lfsr[13] & lfsr[14], "");
    end
    // R8: reset in mid-stall clears the pending state
    step(1, 4, 1, 4, 0, 0, 0, "R1");
    rst_n = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    rst_n = 1'b1;
    step(1, 4, 1, 4, 0, 0, 0, "R8");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule